// File: doc/BRIEF.md
# Dual-Clock Cascadable Up/Down Counter

This block is a small binary counter driven by two separate count inputs. A rising edge on the up input adds one to the count and a rising edge on the down input subtracts one. A parallel preset can be forced into the count with an active-low load input. An active-high clear forces the count to zero and takes priority over the load. Both the clear and the load take effect at the count output in the same cycle they are asserted. The register underneath them follows on the next system clock edge.

The block runs entirely on one system clock. Both count inputs pass through a chain of synchronizer flops, and rising edges are detected at the end of that chain. Two active-low terminal-count outputs are provided. The carry output is low while the count sits at its maximum value and the synchronized up level is low. The borrow output is low while the count sits at zero and the synchronized down level is low. Each of them rises on the same system clock edge that wraps the count. It can therefore be wired straight into the up or down input of a following stage, which then sees its own rising edge exactly at wrap-around.

The intended usage holds one count input high while the other is pulsed.

Top module: `udc_dual_clock_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0. The synchronizer stages are set to the high level. After release with both count inputs held high, `count_o` = 0, `carry_n_o` = 1 and `borrow_n_o` = 1.
- R2: A low-to-high change on `cnt_up_i` increments the count by one. The new value appears after the third rising clock edge that follows the input change: two synchronizer stages, then the count register.
- R3: A low-to-high change on `cnt_dn_i` decrements the count by one, with the same three-edge latency as R2.
- R4: Counting up from 15 gives 0, and counting down from 0 gives 15 (WIDTH = 4).
- R5: When rising edges on both count inputs reach the edge detector in the same cycle, the count is left unchanged.
- R6: While `load_n_i` is 0 and `clear_i` is 0, `count_o` equals `preset_i` in the same cycle. From the next clock edge on, the register holds the preset.
- R7: While `clear_i` is 1, `count_o` is 0 in the same cycle whatever `load_n_i` and `preset_i` are. From the next clock edge on, the register holds 0.
- R8: Count edges detected while `clear_i` or `load_n_i` is asserted are discarded. After release, the count equals the cleared or loaded value.
- R9: `carry_n_o` is 0 exactly when `count_o` is all ones and the synchronized up level is 0. It returns to 1 on the same clock edge that wraps the count to 0.
- R10: `borrow_n_o` is 0 exactly when `count_o` is 0 and the synchronized down level is 0. It returns to 1 on the same clock edge that wraps the count to all ones.
- R11: When the carry and borrow outputs of one instance drive the up and down inputs of a second instance, the second instance steps once per wrap of the first, in the matching direction.
- R12: A count input held high through reset and after its release produces no count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up_i | input | 1 | Up count input, rising edge adds one |
| cnt_dn_i | input | 1 | Down count input, rising edge subtracts one |
| clear_i | input | 1 | Active-high clear, overrides load and counting |
| load_n_i | input | 1 | Active-low parallel load of the preset |
| preset_i | input | WIDTH | Preset value for the parallel load |
| count_o | output | WIDTH | Current count value |
| carry_n_o | output | 1 | Active-low terminal count while counting up |
| borrow_n_o | output | 1 | Active-low terminal count while counting down |

## Verification
The bench counts two cascaded instances through several full wraps in both directions. It checks that the high stage steps exactly once per wrap and on the matching side. A carry that rose one cycle before the wrap, or that followed the raw input rather than the synchronized level, would make the high stage step early or twice. The bench drives coincident edges on both inputs and edges held under clear or load; a design that let either through would drift from the model's value. It also holds an input high through reset, where a synchronizer that reset low would add a spurious step, and it asserts clear together with load to show that clear wins.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } cnt_op_e;

  // Priority: clear, then load, then a single-direction edge.
  function automatic cnt_op_e pick_op(input logic clr, input logic ld_n,
                                      input logic up_rise, input logic dn_rise);
    cnt_op_e op;
    if (clr)                       op = OP_CLEAR;
    else if (!ld_n)                op = OP_LOAD;
    else if (up_rise && !dn_rise)  op = OP_INC;
    else if (dn_rise && !up_rise)  op = OP_DEC;
    else                           op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b1;
        else     chain_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b1;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = prev_q;
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] cnt_q
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        OP_CLEAR: cnt_q <= '0;
        OP_LOAD:  cnt_q <= preset_i;
        OP_INC:   cnt_q <= cnt_q + STEP;
        OP_DEC:   cnt_q <= cnt_q - STEP;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/udc_term_detect.sv
module udc_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;

  assign carry_n_o  = ~((value_i == TOP_VAL) & ~up_lvl_i);
  assign borrow_n_o = ~((value_i == '0)      & ~dn_lvl_i);

endmodule

// File: rtl/udc_dual_clock_counter.sv
module udc_dual_clock_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic             up_lvl, up_rise;
  logic             dn_lvl, dn_rise;
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q;

  udc_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (cnt_up_i),
    .level_o (up_lvl),
    .rise_o  (up_rise)
  );

  udc_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (cnt_dn_i),
    .level_o (dn_lvl),
    .rise_o  (dn_rise)
  );

  assign op = pick_op(clear_i, load_n_i, up_rise, dn_rise);

  udc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .preset_i (preset_i),
    .cnt_q    (cnt_q)
  );

  // Clear and load reach the output in the cycle they are asserted.
  always_comb begin
    if (clear_i)        count_o = '0;
    else if (!load_n_i) count_o = preset_i;
    else                count_o = cnt_q;
  end

  udc_term_detect #(.WIDTH(WIDTH)) u_term (
    .value_i    (count_o),
    .up_lvl_i   (up_lvl),
    .dn_lvl_i   (dn_lvl),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

endmodule

// File: rtl/udc_counter_checker.sv
module udc_counter_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o,
  input logic [WIDTH-1:0] cnt_q,
  input logic             up_rise,
  input logic             dn_rise
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cnt_q == '0);

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rise && !dn_rise && !clear_i && load_n_i) |=>
      cnt_q == WIDTH'($past(cnt_q) + WIDTH'(1)));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rise && !up_rise && !clear_i && load_n_i) |=>
      cnt_q == WIDTH'($past(cnt_q) - WIDTH'(1)));

  // R5
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rise && dn_rise && !clear_i && load_n_i) |=> $stable(cnt_q));

  // R6
  load_view_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !load_n_i) |=> cnt_q == $past(preset_i));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |-> count_o == '0);

  // R9
  carry_low_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |-> count_o == ALL_ONES);

  // R10
  borrow_low_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n_o |-> count_o == '0);

endmodule

bind udc_dual_clock_counter udc_counter_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clear_i    (clear_i),
  .load_n_i   (load_n_i),
  .preset_i   (preset_i),
  .count_o    (count_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o),
  .cnt_q      (cnt_q),
  .up_rise    (up_rise),
  .dn_rise    (dn_rise)
);

// File: tb/udc_dual_clock_counter_tb.sv
`timescale 1ns/1ps
module udc_dual_clock_counter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up = 1'b1, dn = 1'b1, clr = 1'b0, ld_n = 1'b1;
  logic [3:0] pre_lo = 4'd0, pre_hi = 4'd0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       cy_lo, bw_lo, cy_hi, bw_hi;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  udc_dual_clock_counter u_dut (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .clear_i(clr),
    .load_n_i(ld_n), .preset_i(pre_lo), .count_o(cnt_lo),
    .carry_n_o(cy_lo), .borrow_n_o(bw_lo));

  udc_dual_clock_counter u_hi (
    .clk(clk), .rst(rst), .cnt_up_i(cy_lo), .cnt_dn_i(bw_lo), .clear_i(clr),
    .load_n_i(ld_n), .preset_i(pre_hi), .count_o(cnt_hi),
    .carry_n_o(cy_hi), .borrow_n_o(bw_hi));

  // Reference model: per stage a count and a 3-sample input history
  // (bit0 newest sample, bit2 oldest).
  int m_cnt[2];
  int m_uh[2];
  int m_dh[2];

  function automatic int vis(int s);
    if (clr)   return 0;
    if (!ld_n) return (s == 0) ? int'(pre_lo) : int'(pre_hi);
    return m_cnt[s];
  endfunction

  function automatic bit exp_carry(int s);
    return !(vis(s) == 15 && ((m_uh[s] >> 2) & 1) == 0);
  endfunction

  function automatic bit exp_borrow(int s);
    return !(vis(s) == 0 && ((m_dh[s] >> 2) & 1) == 0);
  endfunction

  task automatic model_step(int s, bit raw_u, bit raw_d);
    bit ur, dr;
    ur = ((m_uh[s] >> 1) & 1) == 1 && ((m_uh[s] >> 2) & 1) == 0;
    dr = ((m_dh[s] >> 1) & 1) == 1 && ((m_dh[s] >> 2) & 1) == 0;
    if (clr)            m_cnt[s] = 0;
    else if (!ld_n)     m_cnt[s] = (s == 0) ? int'(pre_lo) : int'(pre_hi);
    else if (ur && !dr) m_cnt[s] = (m_cnt[s] + 1) % 16;
    else if (dr && !ur) m_cnt[s] = (m_cnt[s] + 15) % 16;
    m_uh[s] = ((m_uh[s] << 1) | int'(raw_u)) & 7;
    m_dh[s] = ((m_dh[s] << 1) | int'(raw_d)) & 7;
  endtask

  always @(posedge clk) begin
    bit c0, b0;
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        m_cnt[s] = 0; m_uh[s] = 7; m_dh[s] = 7;
      end
    end else begin
      c0 = exp_carry(0);
      b0 = exp_borrow(0);
      model_step(0, up, dn);
      model_step(1, c0, b0);
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t",
               cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("low count",  int'(cnt_lo), vis(0));
      cmp("low carry",  int'(cy_lo),  int'(exp_carry(0)));
      cmp("low borrow", int'(bw_lo),  int'(exp_borrow(0)));
      cmp("high count", int'(cnt_hi), vis(1));
      cmp("high carry", int'(cy_hi),  int'(exp_carry(1)));
      cmp("high borrow",int'(bw_hi),  int'(exp_borrow(1)));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_up(int n);
    for (int i = 0; i < n; i++) begin
      up = 1'b0; tick(5);
      up = 1'b1; tick(5);
    end
  endtask

  task automatic pulse_dn(int n);
    for (int i = 0; i < n; i++) begin
      dn = 1'b0; tick(5);
      dn = 1'b1; tick(5);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(4);
    // R1: reset state; R12: inputs held high through reset give no step
    rst = 1'b0;
    tick(2);
    cur_req = "R12";
    tick(6);
    // R2: increments with three-edge latency, checked every cycle
    cur_req = "R2";
    pulse_up(5);
    // R3: decrements
    cur_req = "R3";
    pulse_dn(3);
    // R4, R9, R11: upward wraps ripple into the high stage
    cur_req = "R4/R9/R11";
    pulse_up(30);
    // R4, R10, R11: downward wraps past zero borrow from the high stage
    cur_req = "R4/R10/R11";
    pulse_dn(45);
    // R5: coincident edges on both inputs
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin
      up = 1'b0; dn = 1'b0; tick(5);
      up = 1'b1; dn = 1'b1; tick(5);
    end
    // R6: parallel load visible in the same cycle
    cur_req = "R6";
    pre_lo = 4'd14; pre_hi = 4'd5;
    ld_n = 1'b0; tick(3);
    ld_n = 1'b1; tick(3);
    pulse_up(3);
    // R8: edges under load are discarded
    cur_req = "R8";
    pre_lo = 4'd9;
    ld_n = 1'b0;
    pulse_up(2);
    pulse_dn(1);
    ld_n = 1'b1; tick(4);
    // R8: edges under clear are discarded
    clr = 1'b1;
    pulse_up(2);
    clr = 1'b0; tick(4);
    // R7: clear overrides load
    cur_req = "R7";
    pre_lo = 4'd11; pre_hi = 4'd3;
    clr = 1'b1; ld_n = 1'b0; tick(3);
    ld_n = 1'b1; tick(2);
    clr = 1'b0; tick(4);
    // R10: borrow at zero, then one more round trip
    cur_req = "R10/R9";
    pulse_dn(2);
    pulse_up(4);
    tick(6);
    finish_run();
  end

endmodule